// File: doc/BRIEF.md
# Synchronous Memory Bus Controller

This block sits between a processor core and its external memory bus and runs every access as a fixed pattern of bus states, one state per system clock. The three states are idle, address and data. A transaction always spends exactly one cycle in the address state. It then stays in the data state for as many cycles as the memory needs, until memory raises a ready input. After every transaction the bus passes through at least one idle cycle.

The core offers a request with a kind (read, write or instruction fetch), a 32-bit address and 32-bit write data. The request is taken only in an idle cycle. The controller latches the request and drives the address and the read, write and fetch strobes for the whole transaction. On a write it enables the tri-state driver of the bidirectional data bus during the data state. On a read or fetch it captures the incoming data on the completing cycle and pulses done to the core.

A single clock replaces the two-phase clock. A step enable decides on which edges the bus state machine may advance. The reset input is asserted asynchronously, and its release reaches the state machine through a two-stage synchroniser.

Top module: `membus_ctrl`

## Requirements
- R1: While rst_n is low, bus_phase is 0 (idle), all strobes, bus_oe, done and req_accept are 0, bus_addr and bus_dout are 0, and rdata is 0. After rst_n rises, requests are ignored on the first two clock edges. A request can be taken on the third edge.
- R2: bus_phase encodes idle as 0, address as 1 and data as 2. req_kind encodes read as 0, write as 1 and fetch as 2. While idle, with step_en high and req_valid high and a kind of 0, 1 or 2, req_accept is high in that cycle and bus_phase is 1 after the next edge.
- R3: A request with req_valid low, or with req_kind equal to 3, has no effect. The bus stays idle and req_accept stays 0.
- R4: On an edge where step_en is low, the bus phase and all latched state keep their values.
- R5: The address state lasts exactly one enabled edge and is always followed by the data state.
- R6: The data state repeats while bus_ready is low. It ends on an enabled edge with bus_ready high, and the bus returns to idle. bus_ready has no effect in the idle and address states.
- R7: In the address and data states, bus_addr carries the latched address. bus_rd is high for reads and fetches, bus_fetch is high for fetches only, and bus_wr is high for writes only. All of these are held stable until the transaction ends, and all are 0 in idle.
- R8: bus_oe is high only in the data state of a write. bus_dout then carries the latched write data and is 0 at all other times.
- R9: On the completing edge of a read or fetch, rdata takes the value on bus_din. rdata then holds until the next read or fetch completes. Writes never change it.
- R10: done is high for exactly the one cycle after the completing edge, which is the first idle cycle.
- R11: A request held pending across a transaction is not taken before the bus has spent one cycle in idle. The address state is always entered from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Lets the bus state machine advance on this edge |
| req_valid | input | 1 | Core presents a request |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 no operation |
| req_addr | input | 32 | Request address |
| req_wdata | input | 32 | Request write data |
| req_accept | output | 1 | Request taken on this edge |
| done | output | 1 | One-cycle transaction completion pulse |
| rdata | output | 32 | Last captured read data |
| bus_addr | output | 32 | Memory address bus |
| bus_rd | output | 1 | Read strobe (reads and fetches) |
| bus_wr | output | 1 | Write strobe |
| bus_fetch | output | 1 | Marks an instruction read |
| bus_oe | output | 1 | Tri-state enable for the data bus driver |
| bus_dout | output | 32 | Data driven onto the bus on writes |
| bus_din | input | 32 | Data sampled from the bus |
| bus_ready | input | 1 | Memory ends the data state |
| bus_phase | output | 2 | Current bus state |

## Verification
The properties allow bus_ready and step_en to take any value on any cycle. They rely only on the core's inputs being stable across each clock edge, and on reset being held for at least one edge. The stimulus changes every input half a cycle away from the active edge. It toggles bus_ready while the bus is idle or in the address state, and it drives junk onto bus_din whenever ready is low, so a capture at the wrong cycle shows up. It keeps a request pending while a transaction is running, and it uses a fixed pattern of disabled edges to test how the state machine holds its state.

// File: rtl/membus_pkg.sv
package membus_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_FETCH = 2'd2,
    OP_NONE  = 2'd3
  } op_e;

  function automatic logic op_reads(input op_e k);
    return (k == OP_READ) || (k == OP_FETCH);
  endfunction

endpackage

// File: rtl/membus_rst_sync.sv
module membus_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) pipe_q <= '0;
        else         pipe_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) pipe_q <= '0;
        else         pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign srst_n = pipe_q[STAGES-1];
endmodule

// File: rtl/membus_seq.sv
module membus_seq
  import membus_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   step_en,
  input  logic   start,
  input  logic   ready,
  output phase_e phase,
  output logic   finish
);
  phase_e ph_q, ph_d;

  // next-state process
  always_comb begin
    ph_d   = ph_q;
    finish = 1'b0;
    if (step_en) begin
      unique case (ph_q)
        PH_IDLE: if (start) ph_d = PH_ADDR;
        PH_ADDR: ph_d = PH_DATA;
        PH_DATA: begin
          if (ready) begin
            ph_d   = PH_IDLE;
            finish = 1'b1;
          end
        end
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  assign phase = ph_q;
endmodule

// File: rtl/membus_req_hold.sv
module membus_req_hold
  import membus_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  op_e           in_kind,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_wdata,
  output op_e           kind_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q
);
  op_e           kind_d;
  logic [AW-1:0] addr_d;
  logic [DW-1:0] wdata_d;

  always_comb begin
    kind_d  = kind_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    if (load) begin
      kind_d  = in_kind;
      addr_d  = in_addr;
      wdata_d = in_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= OP_NONE;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      kind_q  <= kind_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
    end
  end
endmodule

// File: rtl/membus_rd_capture.sv
module membus_rd_capture #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          finish,
  input  logic          is_read,
  input  logic [DW-1:0] bus_din,
  output logic [DW-1:0] rdata,
  output logic          done
);
  logic [DW-1:0] rdata_d;
  logic          cap_en;

  assign cap_en = finish && is_read;

  always_comb begin
    rdata_d = rdata;
    if (cap_en) rdata_d = bus_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      done  <= 1'b0;
    end else begin
      rdata <= rdata_d;
      done  <= finish;
    end
  end
endmodule

// File: rtl/membus_ctrl.sv
module membus_ctrl
  import membus_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_accept,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic              bus_fetch,
  output logic              bus_oe,
  output logic [DATA_W-1:0] bus_dout,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              bus_ready,
  output logic [1:0]        bus_phase
);
  logic              core_rst_n;
  phase_e            phase;
  logic              finish;
  logic              start;
  op_e               in_kind;
  op_e               kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              in_txn;

  membus_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (core_rst_n)
  );

  assign in_kind = op_e'(req_kind);
  assign start   = core_rst_n && (phase == PH_IDLE) && step_en &&
                   req_valid && (in_kind != OP_NONE);

  membus_seq u_seq (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .step_en (step_en),
    .start   (start),
    .ready   (bus_ready),
    .phase   (phase),
    .finish  (finish)
  );

  membus_req_hold #(.AW(ADDR_W), .DW(DATA_W)) u_hold (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .load     (start),
    .in_kind  (in_kind),
    .in_addr  (req_addr),
    .in_wdata (req_wdata),
    .kind_q   (kind_q),
    .addr_q   (addr_q),
    .wdata_q  (wdata_q)
  );

  membus_rd_capture #(.DW(DATA_W)) u_cap (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .finish  (finish),
    .is_read (op_reads(kind_q)),
    .bus_din (bus_din),
    .rdata   (rdata),
    .done    (done)
  );

  assign in_txn = (phase != PH_IDLE);

  always_comb begin
    bus_addr  = in_txn ? addr_q : '0;
    bus_rd    = in_txn && op_reads(kind_q);
    bus_fetch = in_txn && (kind_q == OP_FETCH);
    bus_wr    = in_txn && (kind_q == OP_WRITE);
    bus_oe    = (phase == PH_DATA) && (kind_q == OP_WRITE);
    bus_dout  = bus_oe ? wdata_q : '0;
  end

  assign req_accept = start;
  assign bus_phase  = phase;
endmodule

// File: rtl/membus_ctrl_chk.sv
module membus_ctrl_chk
  import membus_pkg::*;
#(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          step_en,
  input logic          bus_ready,
  input logic          req_accept,
  input logic          done,
  input logic [1:0]    bus_phase,
  input logic [AW-1:0] bus_addr,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic          bus_fetch,
  input logic          bus_oe
);
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (bus_phase == PH_IDLE && !bus_rd && !bus_wr && !bus_oe && !done));

  a_r2_accept_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |=> bus_phase == PH_ADDR);

  a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_phase == PH_IDLE && !req_accept) |=> bus_phase == PH_IDLE);

  a_r4_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(bus_phase));

  a_r5_addr_once: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_phase == PH_ADDR && step_en) |=> bus_phase == PH_DATA);

  a_r6_wait_state: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_phase == PH_DATA && !bus_ready) |=> bus_phase == PH_DATA);

  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_phase != PH_IDLE && $past(bus_phase) != PH_IDLE) |->
      ($stable(bus_addr) && $stable(bus_rd) && $stable(bus_wr) && $stable(bus_fetch)));

  a_r7_strobe_mix: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr) && (!bus_fetch || bus_rd));

  a_r8_oe_write: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (bus_wr && bus_phase == PH_DATA));

  a_r10_done_after: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (bus_phase == PH_IDLE && $past(bus_phase) == PH_DATA));

  a_r11_addr_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_phase == PH_ADDR && $past(bus_phase) != PH_ADDR) |-> $past(bus_phase) == PH_IDLE);
endmodule

bind membus_ctrl membus_ctrl_chk #(.AW(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .step_en    (step_en),
  .bus_ready  (bus_ready),
  .req_accept (req_accept),
  .done       (done),
  .bus_phase  (bus_phase),
  .bus_addr   (bus_addr),
  .bus_rd     (bus_rd),
  .bus_wr     (bus_wr),
  .bus_fetch  (bus_fetch),
  .bus_oe     (bus_oe)
);

// File: tb/membus_ctrl_test.sv
module membus_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_en = 1'b1;
  logic        drv_valid = 1'b0;
  logic [1:0]  drv_kind = 2'd0;
  logic [31:0] drv_addr = '0;
  logic [31:0] drv_wdata = '0;
  logic [31:0] bus_din = '0;
  logic        bus_ready = 1'b0;
  logic        req_accept, done, bus_rd, bus_wr, bus_fetch, bus_oe;
  logic [31:0] rdata, bus_addr, bus_dout;
  logic [1:0]  bus_phase;

  always #(CLK_PERIOD/2) clk = ~clk;

  membus_ctrl uut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .req_valid(drv_valid),
    .req_kind(drv_kind), .req_addr(drv_addr), .req_wdata(drv_wdata),
    .req_accept(req_accept), .done(done), .rdata(rdata), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_fetch(bus_fetch), .bus_oe(bus_oe),
    .bus_dout(bus_dout), .bus_din(bus_din), .bus_ready(bus_ready),
    .bus_phase(bus_phase)
  );

  typedef struct {
    logic [1:0]  kind;
    logic [31:0] addr;
    logic [31:0] wdata;
    int          waits;
  } txn_t;

  txn_t        q[$];
  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;
  bit          stall = 0;
  bit          qmode = 0;
  logic [1:0]  m_rs = 2'b00;
  int          m_ph = 0;
  logic [1:0]  m_kind = 2'd3;
  logic [31:0] m_addr = '0, m_wdata = '0, m_rdata = '0;
  logic        m_done = 1'b0;
  int          m_wait = 0;
  logic [31:0] mem[logic [31:0]];

  function automatic logic [31:0] memval(logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return a ^ 32'hA5A5_5A5A;
  endfunction

  // Behavioural reference: bus state per edge, per R1..R11
  always @(posedge clk) begin : model
    logic act;
    act = m_rs[1];
    if (!rst_n) begin
      m_rs = 2'b00; m_ph = 0; m_done = 1'b0; m_rdata = '0;
      m_kind = 2'd3; m_addr = '0; m_wdata = '0; m_wait = 0;
    end else begin
      m_rs   = {m_rs[0], 1'b1};
      m_done = 1'b0;
      if (act && step_en) begin
        case (m_ph)
          0: if (drv_valid && drv_kind != 2'd3) begin
               m_kind = drv_kind; m_addr = drv_addr; m_wdata = drv_wdata;
               m_wait = (qmode && q.size() > 0) ? q[0].waits : 0;
               if (qmode && q.size() > 0) void'(q.pop_front());
               m_ph = 1;
             end
          1: m_ph = 2;
          default: if (bus_ready) begin
               if (m_kind == 2'd1) mem[m_addr] = m_wdata;
               else                m_rdata = bus_din;
               m_done = 1'b1;
               m_ph   = 0;
             end else if (m_wait > 0) m_wait--;
        endcase
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic check_all();
    logic inb, e_acc, e_oe;
    inb   = (m_ph != 0);
    e_acc = m_rs[1] && m_ph == 0 && step_en && drv_valid && drv_kind != 2'd3;
    e_oe  = (m_ph == 2) && (m_kind == 2'd1);
    chk("R1/R2/R5/R6/R11 bus_phase", {30'd0, bus_phase}, m_ph);
    chk("R2/R3/R4 req_accept", {31'd0, req_accept}, {31'd0, e_acc});
    chk("R7 bus_addr", bus_addr, inb ? m_addr : 32'd0);
    chk("R7 bus_rd", {31'd0, bus_rd}, {31'd0, inb && (m_kind == 2'd0 || m_kind == 2'd2)});
    chk("R7 bus_wr", {31'd0, bus_wr}, {31'd0, inb && m_kind == 2'd1});
    chk("R7 bus_fetch", {31'd0, bus_fetch}, {31'd0, inb && m_kind == 2'd2});
    chk("R8 bus_oe", {31'd0, bus_oe}, {31'd0, e_oe});
    chk("R8 bus_dout", bus_dout, e_oe ? m_wdata : 32'd0);
    chk("R10 done", {31'd0, done}, {31'd0, m_done});
    chk("R9 rdata", rdata, m_rdata);
  endtask

  task automatic drive_next();
    cyc++;
    step_en = stall ? (cyc % 3 != 1) : 1'b1;
    if (qmode) begin
      if (q.size() > 0) begin
        drv_valid = 1'b1; drv_kind = q[0].kind;
        drv_addr = q[0].addr; drv_wdata = q[0].wdata;
      end else drv_valid = 1'b0;
    end
    // R6: ready toggles outside the data state and must be ignored there
    if (m_ph == 2) bus_ready = (m_wait == 0);
    else           bus_ready = cyc[0];
    bus_din = (m_ph == 2 && m_wait == 0) ? memval(m_addr) : (32'hDEAD_0000 | cyc);
  endtask

  task automatic tick();
    @(negedge clk);
    check_all();
    drive_next();
  endtask

  task automatic push(logic [1:0] k, logic [31:0] a, logic [31:0] d, int w);
    txn_t t;
    t.kind = k; t.addr = a; t.wdata = d; t.waits = w;
    q.push_back(t);
  endtask

  task automatic drain();
    int n;
    n = 0;
    while ((q.size() > 0 || m_ph != 0) && n < 2000) begin
      tick();
      n++;
    end
    if (n >= 2000) begin
      errors++;
      $display("FAIL watchdog: drain did not finish");
    end
    repeat (3) tick();
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (4) tick();
    chk("R1 reset phase", {30'd0, bus_phase}, 32'd0);
    chk("R1 reset rdata", rdata, 32'd0);
    // R1: request offered at release is held off for two edges
    rst_n = 1'b1;
    drv_valid = 1'b1; drv_kind = 2'd0; drv_addr = 32'h0000_0040;
    tick();
    chk("R1 no accept first edge", {30'd0, bus_phase}, 32'd0);
    tick();
    chk("R1 no accept second edge", {30'd0, bus_phase}, 32'd0);
    drv_valid = 1'b0;
    repeat (6) tick();

    // R3: invalid or absent requests
    drv_valid = 1'b0; drv_kind = 2'd1; drv_addr = 32'h100;
    repeat (3) tick();
    drv_valid = 1'b1; drv_kind = 2'd3;
    repeat (3) tick();
    chk("R3 kind 3 ignored", {30'd0, bus_phase}, 32'd0);
    drv_valid = 1'b0;
    tick();

    // R2/R5/R6/R7/R8/R9/R10/R11: mixed transactions, request held pending
    qmode = 1;
    push(2'd1, 32'h0000_1000, 32'h1111_2222, 0);
    push(2'd0, 32'h0000_1000, 32'h0, 0);
    push(2'd2, 32'h0000_2004, 32'h0, 2);
    push(2'd1, 32'h0000_3008, 32'hCAFE_F00D, 3);
    push(2'd0, 32'h0000_3008, 32'h0, 1);
    push(2'd0, 32'h0000_7777, 32'h0, 0);
    drain();

    // R4: disabled edges freeze state
    stall = 1;
    push(2'd2, 32'h0000_3008, 32'h0, 1);
    push(2'd1, 32'h0000_4000, 32'h0BAD_BEEF, 2);
    push(2'd0, 32'h0000_4000, 32'h0, 0);
    push(2'd1, 32'hFFFF_FFFC, 32'hFFFF_FFFF, 0);
    push(2'd2, 32'hFFFF_FFFC, 32'h0, 4);
    drain();
    stall = 0;

    // R1: reset in the middle of a long data state
    push(2'd0, 32'h0000_5000, 32'h0, 8);
    repeat (5) tick();
    rst_n = 1'b0;
    q.delete();
    repeat (2) tick();
    chk("R1 mid-transaction reset idle", {30'd0, bus_phase}, 32'd0);
    rst_n = 1'b1;
    repeat (5) tick();
    push(2'd0, 32'h0000_1000, 32'h0, 0);
    drain();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule